// File: doc/BRIEF.md
# Virtual output queue manager

This block is the input-side cell store for one port of a switched fabric with `N_DEST` outputs. Every arriving cell carries a destination number and a partial-transfer flag. It is appended to a logical queue kept for that destination, so cells waiting for a busy output never hold back cells bound elsewhere. All queues share one storage array. Each queue is a linked list threaded through that array, and a bitmap pool tracks the free slots.

The block presents one request bit per destination to a central allocator. A grant names a destination. The block answers by sending up to two cells from the head of that queue on consecutive cycles. The second cell, or the only cell, is flagged as the last unit of the transfer. A grant that cannot be served raises a one-cycle error flag and moves nothing. When the array is full, new cells are discarded and counted. Stored cells are never overwritten.

Top module: `voq_manager`

## Requirements
- R1: `req[d]` is high exactly when queue `d` holds two or more cells, or holds one cell whose partial flag (`in_part` at arrival) was set. It is visible the cycle after the enqueue or dequeue that changes the queue.
- R2: A grant to a queue holding at least two cells yields `out_valid` on the two cycles after the grant edge. Both cells carry `out_dest` equal to the granted destination. `out_last` is 0 on the first cell and 1 on the second.
- R3: A grant to a queue holding exactly one cell yields that single cell on the cycle after the grant, with `out_last` 1, and no second cell.
- R4: Cells of one destination leave in arrival order. `out_data` and `out_part` equal the values given at enqueue.
- R5: Cells queued for one destination are sent on a grant to another destination without waiting for the first destination's cells to drain.
- R6: A grant to an empty queue moves no cell (`out_valid` stays 0) and sets `grant_err` for exactly one cycle, the cycle after the grant.
- R7: A grant arriving while the second cell of a transfer is being sent is ignored. `grant_err` pulses the following cycle, and the named queue keeps its cells.
- R8: A cell arriving while all `DEPTH` slots hold cells is discarded. `drop_cnt` rises by one, saturating at all ones, and every stored cell is still delivered intact.
- R9: Slots released by transmitted cells can be reused, so after a full drain the buffer accepts `DEPTH` new cells without a drop.
- R10: After reset, `req`, `out_valid`, `grant_err` and `drop_cnt` are all zero.
- R11: An enqueue and a dequeue to the same queue in one cycle are both honoured. This holds when the queue holds exactly one cell and when it holds two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A cell is offered this cycle |
| in_dest | input | DEST_W | Destination of the offered cell |
| in_part | input | 1 | Offered cell closes a partial transfer |
| in_data | input | CELL_W | Cell payload |
| req | output | N_DEST | Per-destination transfer request |
| grant_valid | input | 1 | Allocator grant strobe |
| grant_dest | input | DEST_W | Destination named by the grant |
| out_valid | output | 1 | A cell is sent this cycle |
| out_dest | output | DEST_W | Destination of the sent cell |
| out_part | output | 1 | Partial flag stored with the sent cell |
| out_last | output | 1 | Sent cell is the final unit of its transfer |
| out_data | output | CELL_W | Sent cell payload |
| grant_err | output | 1 | One-cycle pulse for a grant that was not served |
| drop_cnt | output | DROP_W | Saturating count of discarded cells |

## Verification
The bench builds the block with `N_DEST=4`, `DEPTH=8`, `CELL_W=16` and `DROP_W=4`. The eight-slot array can be filled in eight pushes, which brings the drop path and slot reuse within a few dozen cycles. A four-bit drop counter reaches saturation after fifteen discarded cells. Sixteen-bit payloads carry the destination and a sequence number, so any reordering or cross-queue leak shows up in the data.

// File: rtl/vq_pkg.sv
package vq_pkg;
   typedef enum logic {
      XF_IDLE   = 1'b0,
      XF_SECOND = 1'b1
   } xfer_state_e;
endpackage

// File: rtl/vq_free_pool.sv
module vq_free_pool #(
   parameter int DEPTH = 16,
   parameter int PTR_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             give,
   input  logic [PTR_W-1:0] give_idx,
   output logic             any_free,
   output logic [PTR_W-1:0] take_idx
);
   logic [DEPTH-1:0] free_q;

   assign any_free = |free_q;

   always_comb begin
      take_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (free_q[i]) take_idx = PTR_W'(i);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         free_q <= '1;
      end else begin
         if (take) free_q[take_idx] <= 1'b0;
         if (give) free_q[give_idx] <= 1'b1;
      end
   end

   // R11
   released_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      give |-> !free_q[give_idx]);
endmodule

// File: rtl/vq_list_ctrl.sv
module vq_list_ctrl #(
   parameter int PTR_W = 4,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enq,
   input  logic             deq,
   input  logic [PTR_W-1:0] slot,
   input  logic [PTR_W-1:0] head_next,
   output logic [PTR_W-1:0] head,
   output logic [PTR_W-1:0] tail,
   output logic [CNT_W-1:0] cnt
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head <= '0;
         tail <= '0;
         cnt  <= '0;
      end else begin
         if (enq) tail <= slot;
         if (deq) begin
            if (cnt == CNT_W'(1)) head <= slot;
            else                  head <= head_next;
         end else if (enq && cnt == '0) begin
            head <= slot;
         end
         case ({enq, deq})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   // R11
   deq_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      deq |-> cnt != '0);
endmodule

// File: rtl/vq_xfer_ctrl.sv
module vq_xfer_ctrl
   import vq_pkg::*;
#(
   parameter int N_DEST = 4,
   parameter int DEST_W = 2,
   parameter int CNT_W  = 5
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         grant_valid,
   input  logic [DEST_W-1:0]            grant_dest,
   input  logic [N_DEST-1:0][CNT_W-1:0] q_cnt,
   output logic                         pop,
   output logic [DEST_W-1:0]            pop_dest,
   output logic                         pop_last,
   output logic                         grant_err
);
   xfer_state_e       st;
   logic [DEST_W-1:0] sec_dest;
   logic              dest_ok;
   logic [CNT_W-1:0]  g_cnt;
   logic              err_d;

   assign dest_ok = int'(grant_dest) < N_DEST;
   assign g_cnt   = dest_ok ? q_cnt[grant_dest] : '0;

   always_comb begin
      pop      = 1'b0;
      pop_dest = grant_dest;
      pop_last = 1'b1;
      err_d    = 1'b0;
      if (st == XF_SECOND) begin
         pop      = 1'b1;
         pop_dest = sec_dest;
         err_d    = grant_valid;
      end else if (grant_valid) begin
         if (g_cnt == '0) begin
            err_d = 1'b1;
         end else begin
            pop      = 1'b1;
            pop_last = g_cnt < CNT_W'(2);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= XF_IDLE;
         sec_dest  <= '0;
         grant_err <= 1'b0;
      end else begin
         grant_err <= err_d;
         if (st == XF_SECOND) begin
            st <= XF_IDLE;
         end else if (pop && !pop_last) begin
            st       <= XF_SECOND;
            sec_dest <= grant_dest;
         end
      end
   end

   // R2
   second_beat_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st == XF_SECOND |-> q_cnt[sec_dest] != '0);
   // R7
   busy_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && st == XF_SECOND) |=> grant_err);
   // R6
   empty_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && st == XF_IDLE && g_cnt == '0) |=> grant_err);
endmodule

// File: rtl/voq_manager.sv
module voq_manager #(
   parameter int N_DEST = 4,
   parameter int DEPTH  = 16,
   parameter int CELL_W = 512,
   parameter int DROP_W = 16,
   localparam int DEST_W = (N_DEST > 1) ? $clog2(N_DEST) : 1,
   localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DEST_W-1:0] in_dest,
   input  logic              in_part,
   input  logic [CELL_W-1:0] in_data,
   output logic [N_DEST-1:0] req,
   input  logic              grant_valid,
   input  logic [DEST_W-1:0] grant_dest,
   output logic              out_valid,
   output logic [DEST_W-1:0] out_dest,
   output logic              out_part,
   output logic              out_last,
   output logic [CELL_W-1:0] out_data,
   output logic              grant_err,
   output logic [DROP_W-1:0] drop_cnt
);
   initial begin
      n_dest_param_chk: assert (N_DEST >= 2) else $error("N_DEST must be at least 2");
      depth_param_chk:  assert (DEPTH >= 2)  else $error("DEPTH must be at least 2");
      width_param_chk:  assert (CELL_W >= 1 && DROP_W >= 1) else $error("widths must be positive");
   end

   logic [CELL_W-1:0] mem      [DEPTH];
   logic              part_mem [DEPTH];
   logic [PTR_W-1:0]  nxt      [DEPTH];

   logic [PTR_W-1:0]             head_q [N_DEST];
   logic [PTR_W-1:0]             tail_q [N_DEST];
   logic [N_DEST-1:0][CNT_W-1:0] cnt_q;

   logic              any_free, enq, pop, pop_last, in_ok;
   logic [PTR_W-1:0]  slot, pop_ptr;
   logic [DEST_W-1:0] pop_dest;
   logic [CNT_W-1:0]  in_cnt;
   logic [PTR_W-1:0]  in_tail;

   assign in_ok   = int'(in_dest) < N_DEST;
   assign enq     = in_valid && any_free && in_ok;
   assign in_cnt  = in_ok ? cnt_q[in_dest] : '0;
   assign in_tail = in_ok ? tail_q[in_dest] : '0;
   assign pop_ptr = head_q[pop_dest];

   vq_free_pool #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_pool (
      .clk(clk), .rst_n(rst_n), .take(enq), .give(pop), .give_idx(pop_ptr),
      .any_free(any_free), .take_idx(slot)
   );

   vq_xfer_ctrl #(.N_DEST(N_DEST), .DEST_W(DEST_W), .CNT_W(CNT_W)) u_xfer (
      .clk(clk), .rst_n(rst_n), .grant_valid(grant_valid), .grant_dest(grant_dest),
      .q_cnt(cnt_q), .pop(pop), .pop_dest(pop_dest), .pop_last(pop_last),
      .grant_err(grant_err)
   );

   for (genvar q = 0; q < N_DEST; q++) begin : g_queue
      logic [CNT_W-1:0] c;
      vq_list_ctrl #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_list (
         .clk(clk), .rst_n(rst_n),
         .enq(enq && in_dest == DEST_W'(q)),
         .deq(pop && pop_dest == DEST_W'(q)),
         .slot(slot), .head_next(nxt[head_q[q]]),
         .head(head_q[q]), .tail(tail_q[q]), .cnt(c)
      );
      assign cnt_q[q] = c;
      assign req[q]   = (c >= CNT_W'(2)) || (c == CNT_W'(1) && part_mem[head_q[q]]);
   end

   always_ff @(posedge clk) begin
      if (enq) begin
         mem[slot]      <= in_data;
         part_mem[slot] <= in_part;
         if (in_cnt != '0) nxt[in_tail] <= slot;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_dest  <= '0;
         out_part  <= 1'b0;
         out_last  <= 1'b0;
         out_data  <= '0;
         drop_cnt  <= '0;
      end else begin
         out_valid <= pop;
         if (pop) begin
            out_dest <= pop_dest;
            out_part <= part_mem[pop_ptr];
            out_last <= pop_last;
            out_data <= mem[pop_ptr];
         end
         if (in_valid && !any_free && drop_cnt != {DROP_W{1'b1}})
            drop_cnt <= drop_cnt + 1'b1;
      end
   end

   // R8
   drop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !any_free && drop_cnt != {DROP_W{1'b1}}) |=> drop_cnt == $past(drop_cnt) + 1'b1);
   // R2
   pair_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |=> (out_valid && out_last && out_dest == $past(out_dest)));
endmodule

// File: tb/voq_manager_tb.sv
module voq_manager_tb_top;
   localparam int ND = 4, DP = 8, CW = 16, DW = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 1'b0, in_part = 1'b0, grant_valid = 1'b0;
   logic [1:0] in_dest = '0, grant_dest = '0;
   logic [CW-1:0] in_data = '0;
   logic [ND-1:0] req;
   logic out_valid, out_part, out_last, grant_err;
   logic [1:0] out_dest;
   logic [CW-1:0] out_data;
   logic [DW-1:0] drop_cnt;

   always #4 clk = ~clk;

   voq_manager #(.N_DEST(ND), .DEPTH(DP), .CELL_W(CW), .DROP_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest), .in_part(in_part),
      .in_data(in_data), .req(req), .grant_valid(grant_valid), .grant_dest(grant_dest),
      .out_valid(out_valid), .out_dest(out_dest), .out_part(out_part), .out_last(out_last),
      .out_data(out_data), .grant_err(grant_err), .drop_cnt(drop_cnt)
   );

   int n_chk = 0, n_fail = 0, seq = 0, drop_exp = 0;
   logic [CW-1:0] mdat [ND][64];
   logic          mprt [ND][64];
   int mrd [ND];
   int mwr [ND];

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int msize(input int d);
      return mwr[d] - mrd[d];
   endfunction

   function automatic int mtotal();
      int t = 0;
      for (int d = 0; d < ND; d++) t += msize(d);
      return t;
   endfunction

   function automatic bit req_exp(input int d);
      return msize(d) >= 2 || (msize(d) == 1 && mprt[d][mrd[d] % 64]);
   endfunction

   task automatic drive_push(input int d, input bit p);
      in_valid = 1'b1; in_dest = 2'(d); in_part = p;
      in_data = {2'(d), 14'(seq)}; seq++;
      if (mtotal() < DP) begin
         mdat[d][mwr[d] % 64] = in_data; mprt[d][mwr[d] % 64] = p; mwr[d]++;
      end else if (drop_exp < 15) drop_exp++;
   endtask

   task automatic push(input int d, input bit p);
      drive_push(d, p);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic check_cell(input int d, input bit last, input string tag);
      logic [CW-1:0] e;
      e = mdat[d][mrd[d] % 64];
      check(out_valid == 1'b1 && out_dest == 2'(d), {tag, " valid/dest"}, {out_valid, out_dest}, {1'b1, 2'(d)});
      check(out_data == e && out_part == mprt[d][mrd[d] % 64], {tag, " data (R4)"}, out_data, e);
      check(out_last == last, {tag, " last"}, out_last, last);
      mrd[d]++;
   endtask

   task automatic grant(input int d, input string tag);
      int n;
      n = msize(d) >= 2 ? 2 : msize(d);
      grant_valid = 1'b1; grant_dest = 2'(d);
      @(negedge clk);
      grant_valid = 1'b0;
      if (n == 0) begin
         check(out_valid == 1'b0 && grant_err == 1'b1, {tag, " empty grant (R6)"}, {out_valid, grant_err}, 2'b01);
      end else begin
         check(grant_err == 1'b0, {tag, " no err"}, grant_err, 0);
         check_cell(d, n == 1, tag);
         if (n == 2) begin
            @(negedge clk);
            check_cell(d, 1'b1, tag);
         end
      end
      @(negedge clk);
      check(out_valid == 1'b0 && grant_err == 1'b0, {tag, " idle after"}, {out_valid, grant_err}, 0);
   endtask

   task automatic check_req(input string tag);
      for (int d = 0; d < ND; d++)
         check(req[d] == req_exp(d), {tag, " req (R1)"}, req[d], req_exp(d));
   endtask

   task automatic t_reset();
      check(req == '0 && out_valid == 1'b0 && grant_err == 1'b0 && drop_cnt == '0,
            "R10 reset state", {req, out_valid, grant_err, drop_cnt}, 0);
   endtask

   task automatic t_request();
      push(0, 1'b0);
      check_req("R1 single plain cell");
      push(0, 1'b0);
      push(1, 1'b1);
      check_req("R1 two cells and partial");
   endtask

   task automatic t_basic_grants();
      grant(0, "R2 pair from queue 0");
      check_req("R1 after pair");
      grant(1, "R3 single partial cell");
      grant(2, "R6 grant to empty queue");
   endtask

   task automatic t_hol_and_busy();
      push(2, 1'b0); push(2, 1'b0); push(2, 1'b0);
      push(3, 1'b0); push(3, 1'b0);
      grant(3, "R5 other destination served first");
      grant_valid = 1'b1; grant_dest = 2'd2;
      @(negedge clk);
      check_cell(2, 1'b0, "R7 first of pair");
      @(negedge clk);
      grant_valid = 1'b0;
      check_cell(2, 1'b1, "R7 second of pair");
      check(grant_err == 1'b1, "R7 busy grant flagged", grant_err, 1);
      @(negedge clk);
      check(out_valid == 1'b0 && grant_err == 1'b0, "R7 busy grant ignored", {out_valid, grant_err}, 0);
      check_req("R7 remaining cell");
      grant(2, "R4 leftover in order");
   endtask

   task automatic t_simultaneous();
      push(0, 1'b0); push(0, 1'b0);
      grant_valid = 1'b1; grant_dest = 2'd0;
      drive_push(0, 1'b1);
      @(negedge clk);
      grant_valid = 1'b0; in_valid = 1'b0;
      check_cell(0, 1'b0, "R11 two-cell queue first");
      @(negedge clk);
      check_cell(0, 1'b1, "R11 two-cell queue second");
      @(negedge clk);
      check_req("R11 new cell kept");
      grant(0, "R11 enqueued cell");
      push(1, 1'b0);
      grant_valid = 1'b1; grant_dest = 2'd1;
      drive_push(1, 1'b0);
      @(negedge clk);
      grant_valid = 1'b0; in_valid = 1'b0;
      check_cell(1, 1'b1, "R11 one-cell queue");
      @(negedge clk);
      grant(1, "R11 one-cell queue refill");
   endtask

   task automatic t_full();
      for (int i = 0; i < DP; i++) push(i % ND, 1'b0);
      check(drop_cnt == '0, "R8 no drop before full", drop_cnt, 0);
      push(1, 1'b0);
      check(drop_cnt == 4'd1, "R8 first drop", drop_cnt, 1);
      for (int i = 0; i < 16; i++) push(i % ND, 1'b1);
      check(drop_cnt == 4'(drop_exp), "R8 drop saturates", drop_cnt, drop_exp);
      check_req("R8 full state");
      for (int d = 0; d < ND; d++) grant(d, "R8 stored cells intact");
      for (int i = 0; i < DP; i++) push((i * 3) % ND, i[0]);
      check(drop_cnt == 4'(drop_exp), "R9 refill without drop", drop_cnt, drop_exp);
      for (int d = 0; d < ND; d++) grant(d, "R9 reused slots");
      for (int d = 0; d < ND; d++) if (msize(d) != 0) grant(d, "R9 reused slots tail");
   endtask

   initial begin
      for (int d = 0; d < ND; d++) begin mrd[d] = 0; mwr[d] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_request();
      t_basic_grants();
      t_hol_and_busy();
      t_simultaneous();
      t_full();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule